// File: doc/BRIEF.md
# Tick-Driven Count/Compare Timer with Routed Interrupt

This block is a timer of the kind a processor keeps next to its control registers. It holds a 32-bit up-counter and a 32-bit compare value. Each tick-enable pulse advances the counter by one. When a tick moves the counter onto the compare value, the block raises a timer request. The request is held until software writes the compare value again. A 3-bit routing input picks which of eight interrupt lines carries the request. A separate pending flag records the same event, but only when the newer-revision feature input is set.

Software loads either register through a write strobe and a shared data bus. A hold input freezes the counter, for example while a debugger has the core stopped. Counter writes still take effect during a hold, but no match can be raised. All outputs come straight from registers.

Top module: `tick_match_timer`

## Requirements
- R1: After a synchronous reset, the counter reads 1, the compare value reads 0, the pending flag reads 0 and all eight interrupt lines are low.
- R2: With hold low and no counter write, each cycle that has the tick enable high adds one to the counter, and the change is visible after that clock edge. The value 0xFFFFFFFF is followed by 0.
- R3: While hold is high, the counter keeps its value through any number of ticks, and no request is raised.
- R4: A counter write loads the data bus into the counter at the next edge and takes priority over a tick in the same cycle. Counting continues from the loaded value. The write never raises a request itself, even when the value loaded equals the compare value.
- R5: A compare write loads the data bus into the compare value at the next edge.
- R6: A tick that moves the counter onto the compare value raises the request at the same edge that the counter changes. The request stays raised while later ticks carry the counter past the compare value.
- R7: The pending flag is set by a match only if the revision input is high in the matching cycle. The request on the interrupt line is raised either way.
- R8: A compare write clears both the pending flag and the request at the next edge. It also wins over a match in the same cycle, leaving both low.
- R9: The interrupt output is a one-hot vector in which bit N, where N is the value of the 3-bit routing input (0 to 7), carries the request. All other bits are 0. A change of the routing input moves a held request to the new bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance pulse |
| cnt_wr | input | 1 | Counter write strobe |
| cmp_wr | input | 1 | Compare write strobe |
| wr_data | input | 32 | Write data for either register |
| cnt_hold | input | 1 | Freezes the counter while high |
| rev2_en | input | 1 | Enables the pending flag |
| irq_sel | input | 3 | Interrupt line number for the request |
| cnt_q | output | 32 | Counter value |
| cmp_q | output | 32 | Compare value |
| pend_q | output | 1 | Timer pending flag |
| irq_vec | output | 8 | Interrupt lines, one-hot or zero |

## Verification
Two pairs of actions can fall in the same cycle. The first is a compare write and the tick that would match. The bench sets the counter one below the compare value and issues the compare write together with that tick. It then expects the counter to advance with both the request and the pending flag still low. The second is a counter write and a tick. This cycle is judged by the counter showing the written value and not the incremented one. The same pairing is used with the written value equal to the compare value, to confirm that no request appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_CNT_W     = 32;
  localparam int unsigned TMR_SEL_W     = 3;
  localparam int unsigned TMR_RESET_CNT = 1;

  typedef enum logic [1:0] {
    CNT_KEEP = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_STEP = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = TMR_CNT_W,
  parameter int unsigned RESET_VAL = TMR_RESET_CNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             hold,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             advance
);
  cnt_op_e op;

  // a load outranks a step; hold only blocks the step
  always_comb begin
    if (wr_en)                op = CNT_LOAD;
    else if (tick_en && !hold) op = CNT_STEP;
    else                      op = CNT_KEEP;
  end

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign advance = (op == CNT_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RESET_VAL);
    end else begin
      case (op)
        CNT_LOAD: cnt_q <= wr_data;
        CNT_STEP: cnt_q <= cnt_inc;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rev2_en,
  output logic [CNT_W-1:0] cmp_q,
  output logic             req_n,
  output logic             pend_q
);
  logic req_q;
  logic hit;
  logic pend_n;

  // only the step that lands on the compare value counts as a hit
  assign hit = advance && (cnt_inc == cmp_q);

  always_comb begin
    req_n  = req_q;
    pend_n = pend_q;
    if (cmp_wr) begin
      req_n  = 1'b0;
      pend_n = 1'b0;
    end else if (hit) begin
      req_n = 1'b1;
      if (rev2_en) pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cmp_wr) cmp_q <= wr_data;
      req_q  <= req_n;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
  import tmr_pkg::*;
#(
  parameter int unsigned SEL_W = TMR_SEL_W,
  localparam int unsigned LINES = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_n,
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] irq_vec
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_vec[i] <= 1'b0;
      else     irq_vec[i] <= req_n && (sel == SEL_W'(i));
    end
  end
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = TMR_CNT_W,
  parameter int unsigned SEL_W     = TMR_SEL_W,
  parameter int unsigned RESET_CNT = TMR_RESET_CNT,
  localparam int unsigned LINES    = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_hold,
  input  logic             rev2_en,
  input  logic [SEL_W-1:0] irq_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             pend_q,
  output logic [LINES-1:0] irq_vec
);
  logic [CNT_W-1:0] cnt_inc;
  logic             advance;
  logic             req_n;

  tmr_count_unit #(.CNT_W(CNT_W), .RESET_VAL(RESET_CNT)) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .hold    (cnt_hold),
    .wr_en   (cnt_wr),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc),
    .advance (advance)
  );

  tmr_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .cnt_inc (cnt_inc),
    .cmp_wr  (cmp_wr),
    .wr_data (wr_data),
    .rev2_en (rev2_en),
    .cmp_q   (cmp_q),
    .req_n   (req_n),
    .pend_q  (pend_q)
  );

  tmr_irq_route #(.SEL_W(SEL_W)) u_route (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .sel     (irq_sel),
    .irq_vec (irq_vec)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned LINES = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             cnt_wr,
  input logic             cmp_wr,
  input logic [CNT_W-1:0] wr_data,
  input logic             cnt_hold,
  input logic             rev2_en,
  input logic [SEL_W-1:0] irq_sel,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             pend_q,
  input logic [LINES-1:0] irq_vec
);
  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_hold && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt_hold && !cnt_wr) |=> $stable(cnt_q));
  // R4
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(wr_data)));
  // R5
  a_r5_cmp_load: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (cmp_q == $past(wr_data)));
  // R7
  a_r7_pend_rev: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(rev2_en));
  // R8
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (!pend_q && (irq_vec == '0)));
  // R9
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_vec));
  // R9
  a_r9_route: assert property (@(posedge clk) disable iff (rst)
    (irq_vec != '0) |-> (irq_vec == (LINES'(1) << $past(irq_sel))));
  // R6
  a_r6_pend_has_req: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (irq_vec != '0));
endmodule

bind tick_match_timer tmr_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .cnt_wr   (cnt_wr),
  .cmp_wr   (cmp_wr),
  .wr_data  (wr_data),
  .cnt_hold (cnt_hold),
  .rev2_en  (rev2_en),
  .irq_sel  (irq_sel),
  .cnt_q    (cnt_q),
  .cmp_q    (cmp_q),
  .pend_q   (pend_q),
  .irq_vec  (irq_vec)
);

// File: tb/tick_match_timer_bench.sv
`timescale 1ns/1ps
module tick_match_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, cnt_wr = 1'b0, cmp_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cnt_hold = 1'b0, rev2_en = 1'b0;
  logic [2:0]  irq_sel = '0;
  logic [31:0] cnt_q, cmp_q;
  logic        pend_q;
  logic [7:0]  irq_vec;

  always #2.5 clk = ~clk;

  tick_match_timer u_tick_match_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
    .wr_data(wr_data), .cnt_hold(cnt_hold), .rev2_en(rev2_en), .irq_sel(irq_sel),
    .cnt_q(cnt_q), .cmp_q(cmp_q), .pend_q(pend_q), .irq_vec(irq_vec)
  );

  typedef struct {
    logic [31:0] cnt;
    logic [31:0] cmp;
    logic        pend;
    logic [7:0]  irq;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // model state, from the requirements
  logic [31:0] m_cnt = 32'd1, m_cmp = '0;
  logic        m_req = 1'b0, m_pend = 1'b0;

  task automatic step(input bit tk, input bit cw, input bit mw, input logic [31:0] d,
                      input bit hd, input bit rv, input logic [2:0] s, input string tag);
    exp_t e;
    bit   hit;
    @(negedge clk);
    tick_en = tk; cnt_wr = cw; cmp_wr = mw; wr_data = d;
    cnt_hold = hd; rev2_en = rv; irq_sel = s;
    hit = tk && !hd && !cw && ((m_cnt + 32'd1) == m_cmp);
    if (cw)            m_cnt = d;
    else if (tk && !hd) m_cnt = m_cnt + 32'd1;
    if (mw) begin
      m_cmp = d; m_req = 1'b0; m_pend = 1'b0;
    end else if (hit) begin
      m_req = 1'b1;
      if (rv) m_pend = 1'b1;
    end
    e.cnt = m_cnt; e.cmp = m_cmp; e.pend = m_pend;
    e.irq = m_req ? (8'd1 << s) : 8'd0;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares each expected item one step after the edge it refers to
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compared++;
        if (cnt_q !== e.cnt || cmp_q !== e.cmp || pend_q !== e.pend || irq_vec !== e.irq) begin
          mismatched++;
          $display("FAIL %s: actual cnt=%h cmp=%h pend=%b irq=%b expected cnt=%h cmp=%h pend=%b irq=%b",
                   e.tag, cnt_q, cmp_q, pend_q, irq_vec, e.cnt, e.cmp, e.pend, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    step(0,0,0,32'h0,0,1,3'd3,"R1 reset");
    step(0,0,0,32'h0,0,1,3'd3,"R1 reset idle");
    // R2 plain counting
    for (int i = 0; i < 3; i++) step(1,0,0,32'h0,0,1,3'd3,"R2 tick");
    step(0,0,0,32'h0,0,1,3'd3,"R2 no tick");
    // R5 compare load, then R6/R7/R9 match on line 3 with rev2
    step(0,0,1,32'd10,0,1,3'd3,"R5 cmp load");
    for (int i = 0; i < 6; i++) step(1,0,0,32'h0,0,1,3'd3,"R6 approach/match");
    for (int i = 0; i < 3; i++) step(1,0,0,32'h0,0,1,3'd3,"R6 held past compare");
    // R9 route change
    step(0,0,0,32'h0,0,1,3'd6,"R9 reroute to 6");
    step(1,0,0,32'h0,0,1,3'd0,"R9 reroute to 0");
    // R8 clear
    step(0,0,1,32'd22,0,1,3'd0,"R8 cmp write clears");
    // R7 match without rev2
    step(0,1,0,32'd20,0,0,3'd5,"R4 cnt load");
    step(1,0,0,32'h0,0,0,3'd5,"R7 tick");
    step(1,0,0,32'h0,0,0,3'd5,"R7 match no pend");
    step(0,0,1,32'd30,0,1,3'd5,"R8 clear again");
    // R3 hold
    step(0,1,0,32'd29,0,1,3'd1,"R4 cnt load 29");
    for (int i = 0; i < 4; i++) step(1,0,0,32'h0,1,1,3'd1,"R3 hold ticks");
    step(1,1,0,32'd50,1,1,3'd1,"R3 R4 load during hold");
    step(1,0,0,32'h0,1,1,3'd1,"R3 hold after load");
    step(1,0,0,32'h0,0,1,3'd1,"R4 resume from load");
    // R4 loading the compare value raises nothing; write beats tick
    step(0,0,1,32'd60,0,1,3'd1,"R5 cmp 60");
    step(1,1,0,32'd60,0,1,3'd1,"R4 load equal to cmp with tick");
    step(1,0,0,32'h0,0,1,3'd1,"R4 no match after equal load");
    step(1,1,0,32'd70,0,1,3'd1,"R4 load wins over tick");
    // R8 compare write in the matching cycle
    step(0,0,1,32'd71,0,1,3'd2,"R5 cmp 71");
    step(1,0,1,32'd100,0,1,3'd2,"R8 cmp write beats match");
    step(0,0,0,32'h0,0,1,3'd2,"R8 stays clear");
    // R2 wrap with match at zero on line 7
    step(0,0,1,32'd0,0,1,3'd7,"R5 cmp 0");
    step(0,1,0,32'hFFFF_FFFE,0,1,3'd7,"R4 load near top");
    step(1,0,0,32'h0,0,1,3'd7,"R2 to all ones");
    step(1,0,0,32'h0,0,1,3'd7,"R2 R6 wrap match");
    step(1,0,0,32'h0,0,1,3'd7,"R6 past after wrap");
    step(0,0,1,32'd5,0,1,3'd7,"R8 final clear");
    repeat (3) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule